// File: doc/BRIEF.md
# Width-Limited Wakeup Broadcast Scheduler

This block sits between the execution pipes and the issue queue of an out-of-order core. Each cycle up to `N` instructions finish. Each one presents its destination physical register tag, a flag telling whether any queued instruction waits on that tag, and a flag telling whether any such waiter is critical. The block drives at most `W` wakeup tags per cycle (`W < N`) onto the broadcast bus. With fewer broadcast tags, each issue-queue entry needs fewer tag comparators.

Tags that nobody waits on are dropped and never take a slot. Tags that only non-critical consumers need may be postponed. Postponed tags, and tags that lose the slot competition, wait in a pending buffer of depth `P`. The buffer keeps oldest-first order. A postponed tag ages, and after a bounded wait it competes as if it were critical, so it cannot starve.

When the buffer cannot take a full group of completions, the block raises a stall towards execution. A pipeline flush removes, in the same cycle, every pending or incoming tag whose reorder sequence number is younger than the flush point.

Top module: `wbs_bcast_sched`

## Requirements
- R1: Each valid broadcast slot carries, unchanged, the `TAG_W`-bit destination tag of a completion that was accepted earlier.
- R2: At most `W` slots are valid in a cycle. Valid slots fill from slot 0 upward with no gap, and unused slots are invalid.
- R3: A completion with `cmp_needed` = 0 is never broadcast and never enters the pending buffer.
- R4: Slots are granted in this fixed class order: pending urgent tags, then new critical tags, then pending non-critical tags, then new non-critical tags. A pending tag is urgent if it was critical on arrival or has aged (R8). Whenever the buffer holds a tag and no flush is active, slot 0 is valid in the next cycle.
- R5: Inside a class, pending tags go oldest first and new tags go by ascending lane index. Leftover new tags join the buffer behind the existing entries, in lane order.
- R6: The outputs are registered. A tag accepted in cycle t appears on the bus no earlier than cycle t+1, and appears in t+1 if it wins a slot in t.
- R7: `stall` is high exactly when the buffer holds more than `P - N` tags. Completions offered while `stall` is high are ignored, and the occupancy does not grow in that cycle.
- R8: A non-critical pending tag that has stayed in the buffer through `AGE_K` clock edges after the edge that stored it becomes urgent.
- R9: In a cycle with `flush` high, every pending or incoming tag whose sequence number is numerically greater than `flush_seq` is removed and never broadcast. Sequence numbers are assumed not to wrap.
- R10: Every accepted, unflushed needed tag is broadcast exactly once. No tag appears in two slots of the same cycle.
- R11: While `rst_n` is low at a clock edge, the pending buffer empties and all slots go invalid. After reset, `stall` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_valid | input | N | Completion present, one bit per lane |
| cmp_tag | input | N*TAG_W | Destination tag per lane, lane l in bits [l*TAG_W +: TAG_W] |
| cmp_needed | input | N | Some queued instruction waits on the lane's tag |
| cmp_crit | input | N | Some waiter on the lane's tag is critical |
| cmp_seq | input | N*SEQ_W | Reorder sequence number per lane |
| flush | input | 1 | Pipeline flush this cycle |
| flush_seq | input | SEQ_W | Flush point; larger sequence numbers are flushed |
| stall | output | 1 | Hold completions; buffer cannot take a full group |
| bc_valid | output | W | Broadcast slot valid, registered |
| bc_tag | output | W*TAG_W | Broadcast slot tag, slot s in bits [s*TAG_W +: TAG_W] |

## Verification
The hardest state to reach from the ports is a non-critical tag that sits in the buffer long enough to be promoted. Promotion only shows when critical tags keep filling every slot, and the promoted tag must then overtake a new critical tag. The stimulus gets there in two steps. It first sends one completion group that is half critical and half non-critical. It then feeds exactly `W` fresh critical tags every cycle, so the non-critical leftovers are starved until their age reaches `AGE_K`. Flush cut points are swept across a buffer that holds tags of mixed age, and an exhaustive sweep covers every needed/critical lane pattern.

// File: rtl/wbs_pkg.sv
// Shared types for the wakeup broadcast scheduler.
// The class encoding is ordered: a numerically smaller class wins a slot first.
package wbs_pkg;

    typedef enum logic [1:0] {
        CLS_PEND_URGENT = 2'd0,
        CLS_NEW_URGENT  = 2'd1,
        CLS_PEND_LAZY   = 2'd2,
        CLS_NEW_LAZY    = 2'd3
    } wake_cls_e;

endpackage

// File: rtl/wbs_rank_select.sv
// Ranks all slot candidates by (class, index) and grants the best W of them.
// Assumes: candidate indices 0..P-1 are pending entries (oldest first) and
// P..M-1 are new lanes in ascending lane order, so index order doubles as
// age order inside every class.
module wbs_rank_select
    import wbs_pkg::*;
#(
    parameter int M  = 12,
    parameter int W  = 2,
    parameter int RW = 4
) (
    input  logic [M-1:0]  cand_vld,
    input  wake_cls_e     cand_cls  [M],
    output logic [M-1:0]  cand_sel,
    output logic [RW-1:0] cand_rank [M]
);

    for (genvar i = 0; i < M; i++) begin : g_rank
        logic [RW-1:0] ahead;

        // Count eligible candidates that outrank candidate i.
        always_comb begin
            ahead = '0;
            for (int j = 0; j < M; j++) begin
                if (j != i && cand_vld[j] &&
                    ((cand_cls[j] < cand_cls[i]) ||
                     (cand_cls[j] == cand_cls[i] && j < i))) begin
                    ahead = ahead + 1'b1;
                end
            end
        end

        assign cand_rank[i] = ahead;
        assign cand_sel[i]  = cand_vld[i] && (ahead < RW'(W));
    end

endmodule

// File: rtl/wbs_slot_mux.sv
// Steers each granted candidate's tag to the slot equal to its rank.
// Assumes: ranks of granted candidates are distinct and below W.
module wbs_slot_mux #(
    parameter int M     = 12,
    parameter int W     = 2,
    parameter int TAG_W = 8,
    parameter int RW    = 4
) (
    input  logic [M-1:0]       cand_sel,
    input  logic [RW-1:0]      cand_rank [M],
    input  logic [TAG_W-1:0]   cand_tag  [M],
    output logic [W-1:0]       slot_vld,
    output logic [W*TAG_W-1:0] slot_tag
);

    for (genvar s = 0; s < W; s++) begin : g_slot
        logic             v;
        logic [TAG_W-1:0] t;

        // OR together the tag of whichever granted candidate owns slot s.
        always_comb begin
            v = 1'b0;
            t = '0;
            for (int i = 0; i < M; i++) begin
                if (cand_sel[i] && cand_rank[i] == RW'(s)) begin
                    v = 1'b1;
                    t = t | cand_tag[i];
                end
            end
        end

        assign slot_vld[s]                 = v;
        assign slot_tag[s*TAG_W +: TAG_W]  = t;
    end

endmodule

// File: rtl/wbs_pend_queue.sv
// Compacting pending-tag buffer. Survivors are packed to the front in
// candidate index order: old pending entries first, then leftover new lanes.
// Retained entries age by one per edge, saturating at AGE_K.
// Assumes: the number of kept candidates never exceeds P (the parent stalls
// the input early enough to guarantee this).
module wbs_pend_queue #(
    parameter int P     = 8,
    parameter int N     = 4,
    parameter int TAG_W = 8,
    parameter int SEQ_W = 16,
    parameter int AGE_K = 3,
    parameter int AGE_W = 2,
    parameter int CNT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [P+N-1:0]    keep,
    input  logic [TAG_W-1:0]  new_tag  [N],
    input  logic [N-1:0]      new_crit,
    input  logic [SEQ_W-1:0]  new_seq  [N],
    output logic [P-1:0]      q_vld,
    output logic [TAG_W-1:0]  q_tag    [P],
    output logic [P-1:0]      q_crit,
    output logic [SEQ_W-1:0]  q_seq    [P],
    output logic [AGE_W-1:0]  q_age    [P],
    output logic [CNT_W-1:0]  q_cnt
);

    localparam int M  = P + N;
    localparam int RW = $clog2(M + 1);

    logic [TAG_W-1:0] u_tag  [M];
    logic [M-1:0]     u_crit;
    logic [SEQ_W-1:0] u_seq  [M];
    logic [AGE_W-1:0] u_age  [M];
    logic [RW-1:0]    pos    [M];

    logic [P-1:0]     n_vld;
    logic [TAG_W-1:0] n_tag  [P];
    logic [P-1:0]     n_crit;
    logic [SEQ_W-1:0] n_seq  [P];
    logic [AGE_W-1:0] n_age  [P];

    // Line up pending and new candidates in one index space, ageing the old ones.
    always_comb begin
        for (int i = 0; i < P; i++) begin
            u_tag[i]  = q_tag[i];
            u_crit[i] = q_crit[i];
            u_seq[i]  = q_seq[i];
            u_age[i]  = (q_age[i] == AGE_W'(AGE_K)) ? q_age[i] : q_age[i] + 1'b1;
        end
        for (int l = 0; l < N; l++) begin
            u_tag[P+l]  = new_tag[l];
            u_crit[P+l] = new_crit[l];
            u_seq[P+l]  = new_seq[l];
            u_age[P+l]  = '0;
        end
    end

    // Destination of each kept candidate: number of kept candidates before it.
    always_comb begin
        logic [RW-1:0] run;
        run = '0;
        for (int i = 0; i < M; i++) begin
            pos[i] = run;
            if (keep[i]) run = run + 1'b1;
        end
    end

    // Gather the candidate landing in each buffer position.
    always_comb begin
        for (int d = 0; d < P; d++) begin
            n_vld[d]  = 1'b0;
            n_tag[d]  = '0;
            n_crit[d] = 1'b0;
            n_seq[d]  = '0;
            n_age[d]  = '0;
            for (int i = 0; i < M; i++) begin
                if (keep[i] && pos[i] == RW'(d)) begin
                    n_vld[d]  = 1'b1;
                    n_tag[d]  = u_tag[i];
                    n_crit[d] = u_crit[i];
                    n_seq[d]  = u_seq[i];
                    n_age[d]  = u_age[i];
                end
            end
        end
    end

    // Buffer storage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_vld  <= '0;
            q_crit <= '0;
            for (int d = 0; d < P; d++) begin
                q_tag[d] <= '0;
                q_seq[d] <= '0;
                q_age[d] <= '0;
            end
        end else begin
            q_vld  <= n_vld;
            q_crit <= n_crit;
            for (int d = 0; d < P; d++) begin
                q_tag[d] <= n_tag[d];
                q_seq[d] <= n_seq[d];
                q_age[d] <= n_age[d];
            end
        end
    end

    // Occupancy of the buffer.
    always_comb begin
        q_cnt = '0;
        for (int d = 0; d < P; d++) q_cnt = q_cnt + CNT_W'(q_vld[d]);
    end

endmodule

// File: rtl/wbs_bcast_sched.sv
// Wakeup broadcast scheduler: accepts up to N completions per cycle and
// drives at most W registered wakeup tags, dropping unneeded tags, deferring
// non-critical ones, ageing deferred ones and honouring flushes.
// Assumes: P >= N, W <= P + N, tags in flight are unique, and sequence
// numbers grow with program order without wrapping.
module wbs_bcast_sched
    import wbs_pkg::*;
#(
    parameter int N     = 4,
    parameter int W     = 2,
    parameter int P     = 8,
    parameter int TAG_W = 8,
    parameter int SEQ_W = 16,
    parameter int AGE_K = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N-1:0]       cmp_valid,
    input  logic [N*TAG_W-1:0] cmp_tag,
    input  logic [N-1:0]       cmp_needed,
    input  logic [N-1:0]       cmp_crit,
    input  logic [N*SEQ_W-1:0] cmp_seq,
    input  logic               flush,
    input  logic [SEQ_W-1:0]   flush_seq,
    output logic               stall,
    output logic [W-1:0]       bc_valid,
    output logic [W*TAG_W-1:0] bc_tag
);

    localparam int M     = P + N;
    localparam int RW    = $clog2(M + 1);
    localparam int AGE_W = $clog2(AGE_K + 1);
    localparam int CNT_W = $clog2(P + 1);

    logic [P-1:0]     pq_vld;
    logic [TAG_W-1:0] pq_tag [P];
    logic [P-1:0]     pq_crit;
    logic [SEQ_W-1:0] pq_seq [P];
    logic [AGE_W-1:0] pq_age [P];
    logic [CNT_W-1:0] pend_cnt;

    logic [TAG_W-1:0] in_tag [N];
    logic [SEQ_W-1:0] in_seq [N];

    logic [M-1:0]     cand_vld;
    wake_cls_e        cand_cls  [M];
    logic [TAG_W-1:0] cand_tag  [M];
    logic [M-1:0]     cand_sel;
    logic [RW-1:0]    cand_rank [M];
    logic [M-1:0]     keep;

    logic [W-1:0]       slot_vld;
    logic [W*TAG_W-1:0] slot_tag;

    // Back-pressure once a full completion group might not fit.
    assign stall = pend_cnt > CNT_W'(P - N);

    // Pending entries as candidates: flushed ones drop out, aged ones turn urgent.
    for (genvar p = 0; p < P; p++) begin : g_pend_cand
        logic killed;
        logic urgent;
        assign killed      = flush && (pq_seq[p] > flush_seq);
        assign urgent      = pq_crit[p] || (pq_age[p] == AGE_W'(AGE_K));
        assign cand_vld[p] = pq_vld[p] && !killed;
        assign cand_cls[p] = urgent ? CLS_PEND_URGENT : CLS_PEND_LAZY;
        assign cand_tag[p] = pq_tag[p];
    end

    // New lanes as candidates: only needed, unstalled, unflushed completions.
    for (genvar l = 0; l < N; l++) begin : g_new_cand
        logic killed;
        assign in_tag[l]     = cmp_tag[l*TAG_W +: TAG_W];
        assign in_seq[l]     = cmp_seq[l*SEQ_W +: SEQ_W];
        assign killed        = flush && (in_seq[l] > flush_seq);
        assign cand_vld[P+l] = cmp_valid[l] && cmp_needed[l] && !stall && !killed;
        assign cand_cls[P+l] = cmp_crit[l] ? CLS_NEW_URGENT : CLS_NEW_LAZY;
        assign cand_tag[P+l] = in_tag[l];
    end

    assign keep = cand_vld & ~cand_sel;

    wbs_rank_select #(
        .M  (M),
        .W  (W),
        .RW (RW)
    ) u_rank (
        .cand_vld  (cand_vld),
        .cand_cls  (cand_cls),
        .cand_sel  (cand_sel),
        .cand_rank (cand_rank)
    );

    wbs_slot_mux #(
        .M     (M),
        .W     (W),
        .TAG_W (TAG_W),
        .RW    (RW)
    ) u_mux (
        .cand_sel  (cand_sel),
        .cand_rank (cand_rank),
        .cand_tag  (cand_tag),
        .slot_vld  (slot_vld),
        .slot_tag  (slot_tag)
    );

    wbs_pend_queue #(
        .P     (P),
        .N     (N),
        .TAG_W (TAG_W),
        .SEQ_W (SEQ_W),
        .AGE_K (AGE_K),
        .AGE_W (AGE_W),
        .CNT_W (CNT_W)
    ) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .keep     (keep),
        .new_tag  (in_tag),
        .new_crit (cmp_crit),
        .new_seq  (in_seq),
        .q_vld    (pq_vld),
        .q_tag    (pq_tag),
        .q_crit   (pq_crit),
        .q_seq    (pq_seq),
        .q_age    (pq_age),
        .q_cnt    (pend_cnt)
    );

    // Register the broadcast slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bc_valid <= '0;
            bc_tag   <= '0;
        end else begin
            bc_valid <= slot_vld;
            bc_tag   <= slot_tag;
        end
    end

endmodule

// File: rtl/wbs_sched_chk.sv
// Property checker for the wakeup broadcast scheduler, bound to the top.
// Assumes: it sees the top's ports and its pending occupancy count.
module wbs_sched_chk #(
    parameter int N     = 4,
    parameter int W     = 2,
    parameter int P     = 8,
    parameter int TAG_W = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       flush,
    input logic                       stall,
    input logic [W-1:0]               bc_valid,
    input logic [W*TAG_W-1:0]         bc_tag,
    input logic [$clog2(P+1)-1:0]     pend_cnt
);

    for (genvar a = 0; a < W; a++) begin : g_pair_a
        for (genvar b = a + 1; b < W; b++) begin : g_pair_b
            // R10
            no_dup_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (bc_valid[a] && bc_valid[b]) |->
                    (bc_tag[a*TAG_W +: TAG_W] != bc_tag[b*TAG_W +: TAG_W]));
        end
    end

    for (genvar s = 1; s < W; s++) begin : g_fill
        // R2
        slot_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
            bc_valid[s] |-> bc_valid[s-1]);
    end

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (pend_cnt <= $past(pend_cnt)));

    // R4
    pend_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_cnt != '0 && !flush) |=> bc_valid[0]);

endmodule

bind wbs_bcast_sched wbs_sched_chk #(
    .N     (N),
    .W     (W),
    .P     (P),
    .TAG_W (TAG_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .stall    (stall),
    .bc_valid (bc_valid),
    .bc_tag   (bc_tag),
    .pend_cnt (pend_cnt)
);

// File: tb/tb_wbs_bcast_sched.sv
module tb_wbs_bcast_sched;

    localparam int CLK_PERIOD = 10;
    localparam int N     = 4;
    localparam int W     = 2;
    localparam int P     = 8;
    localparam int TAG_W = 8;
    localparam int SEQ_W = 16;
    localparam int AGE_K = 3;
    localparam int NTAGS = 1 << TAG_W;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [N-1:0]       cmp_valid = '0;
    logic [N*TAG_W-1:0] cmp_tag = '0;
    logic [N-1:0]       cmp_needed = '0;
    logic [N-1:0]       cmp_crit = '0;
    logic [N*SEQ_W-1:0] cmp_seq = '0;
    logic               flush = 1'b0;
    logic [SEQ_W-1:0]   flush_seq = '0;
    logic               stall;
    logic [W-1:0]       bc_valid;
    logic [W*TAG_W-1:0] bc_tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    wbs_bcast_sched #(
        .N(N), .W(W), .P(P), .TAG_W(TAG_W), .SEQ_W(SEQ_W), .AGE_K(AGE_K)
    ) dut (
        .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_tag(cmp_tag),
        .cmp_needed(cmp_needed), .cmp_crit(cmp_crit), .cmp_seq(cmp_seq),
        .flush(flush), .flush_seq(flush_seq), .stall(stall),
        .bc_valid(bc_valid), .bc_tag(bc_tag)
    );

    typedef struct {
        int tag;
        bit crit;
        int seq;
        int age;
    } ent_t;

    // Ledger states: 0 idle/cancelled, 1 owed a broadcast, 2 sent, 3 must never be sent.
    ent_t  pq[$];
    bit    exp_v [W];
    int    exp_t [W];
    int    ledger [NTAGS];
    int    lane_tag [N];
    int    lane_seq [N];
    int    n_chk = 0;
    int    n_fail = 0;
    int    next_tag = 1;
    int    next_seq = 1;
    string req = "R11";
    bit    done = 1'b0;

    task automatic chk(input bit ok, input string r, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", r, what, act, expv);
        end
    endtask

    // Compare the registered slots with the model and settle the tag ledger.
    task automatic check_outputs();
        bit gap = 1'b0;
        bit hole = 1'b0;
        for (int s = 0; s < W; s++) begin
            int t = int'(bc_tag[s*TAG_W +: TAG_W]);
            chk(bc_valid[s] == exp_v[s], req, "slot valid", int'(bc_valid[s]), int'(exp_v[s]));
            if (exp_v[s]) chk(t == exp_t[s], req, "slot tag", t, exp_t[s]);
            if (bc_valid[s]) begin
                if (gap) hole = 1'b1;
                if (ledger[t] == 3)      chk(1'b0, "R3", "unneeded or ignored tag broadcast", t, -1);
                else if (ledger[t] == 2) chk(1'b0, "R10", "tag broadcast twice", t, -1);
                else if (ledger[t] == 0) chk(1'b0, "R9", "cancelled tag broadcast", t, -1);
                else begin
                    chk(1'b1, "R10", "owed tag broadcast", t, t);
                    ledger[t] = 2;
                end
            end else begin
                gap = 1'b1;
            end
        end
        chk(!hole, "R2", "valid slot above an empty one", int'(bc_valid), 0);
    endtask

    // One model cycle following the requirements.
    task automatic model_step(input logic [N-1:0] v, input logic [N-1:0] nd,
                              input logic [N-1:0] cr, input bit fl, input int fs);
        bit   st = (pq.size() > P - N);
        ent_t live[$];
        ent_t nw[$];
        ent_t ord[$];
        bit   sent [NTAGS];
        foreach (pq[k]) begin
            if (fl && pq[k].seq > fs) ledger[pq[k].tag] = 0;
            else live.push_back(pq[k]);
        end
        for (int l = 0; l < N; l++) begin
            if (v[l]) begin
                if (st || !nd[l] || (fl && lane_seq[l] > fs)) ledger[lane_tag[l]] = 3;
                else begin
                    ent_t e;
                    e.tag = lane_tag[l]; e.crit = cr[l]; e.seq = lane_seq[l]; e.age = 0;
                    ledger[lane_tag[l]] = 1;
                    nw.push_back(e);
                end
            end
        end
        foreach (live[k]) if (live[k].crit || live[k].age >= AGE_K) ord.push_back(live[k]);
        foreach (nw[k])   if (nw[k].crit) ord.push_back(nw[k]);
        foreach (live[k]) if (!(live[k].crit || live[k].age >= AGE_K)) ord.push_back(live[k]);
        foreach (nw[k])   if (!nw[k].crit) ord.push_back(nw[k]);
        for (int s = 0; s < W; s++) begin
            exp_v[s] = (s < ord.size());
            exp_t[s] = exp_v[s] ? ord[s].tag : 0;
            if (exp_v[s]) sent[ord[s].tag] = 1'b1;
        end
        pq.delete();
        foreach (live[k]) if (!sent[live[k].tag]) begin
            ent_t e = live[k];
            e.age = (e.age + 1 > AGE_K) ? AGE_K : e.age + 1;
            pq.push_back(e);
        end
        foreach (nw[k]) if (!sent[nw[k].tag]) pq.push_back(nw[k]);
        if (pq.size() > P) chk(1'b0, "R7", "buffer overflow in model", pq.size(), P);
    endtask

    task automatic tick(input logic [N-1:0] v, input logic [N-1:0] nd,
                        input logic [N-1:0] cr, input bit fl, input int fs);
        @(negedge clk);
        check_outputs();
        chk(stall == (pq.size() > P - N), "R7", "stall", int'(stall), int'(pq.size() > P - N));
        for (int l = 0; l < N; l++) begin
            if (v[l]) begin
                lane_tag[l] = next_tag % NTAGS;
                chk(ledger[lane_tag[l]] != 1, "R10", "tag still owed at reuse", lane_tag[l], -1);
                lane_seq[l] = next_seq;
                next_tag++;
                next_seq++;
            end else begin
                lane_tag[l] = 0;
                lane_seq[l] = 0;
            end
            cmp_tag[l*TAG_W +: TAG_W] = lane_tag[l][TAG_W-1:0];
            cmp_seq[l*SEQ_W +: SEQ_W] = lane_seq[l][SEQ_W-1:0];
        end
        cmp_valid  = v;
        cmp_needed = nd;
        cmp_crit   = cr;
        flush      = fl;
        flush_seq  = fs[SEQ_W-1:0];
        model_step(v, nd, cr, fl, fs);
    endtask

    task automatic idle();
        tick('0, '0, '0, 1'b0, 0);
    endtask

    task automatic drain();
        while (pq.size() > 0) idle();
        idle();
    endtask

    initial begin
        foreach (ledger[t]) ledger[t] = 0;
        foreach (exp_v[s]) begin exp_v[s] = 1'b0; exp_t[s] = 0; end

        // Reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(bc_valid == '0, "R11", "slots during reset", int'(bc_valid), 0);
        chk(stall == 1'b0, "R11", "stall during reset", int'(stall), 0);
        rst_n = 1'b1;

        // Single tag passes through unchanged one cycle later
        req = "R1 R6";
        tick(4'b0001, 4'b0001, 4'b0001, 1'b0, 0);
        tick(4'b0100, 4'b0100, 4'b0000, 1'b0, 0);
        drain();

        // Unneeded completions never take a slot
        req = "R3";
        tick(4'b1111, 4'b0000, 4'b1010, 1'b0, 0);
        tick(4'b1111, 4'b0101, 4'b1111, 1'b0, 0);
        drain();

        // Exhaustive needed x critical lane patterns
        req = "R4 R5";
        for (int nd = 0; nd < 16; nd++) begin
            for (int cr = 0; cr < 16; cr++) begin
                tick(4'hF, 4'(nd), 4'(cr), 1'b0, 0);
                drain();
            end
        end

        // Starve non-critical tags until they age into urgency
        req = "R8";
        for (int pat = 0; pat < 3; pat++) begin
            tick(4'hF, 4'hF, (pat == 0) ? 4'b0011 : (pat == 1) ? 4'b1100 : 4'b0101, 1'b0, 0);
            repeat (8) tick(4'b0011, 4'b0011, 4'b0011, 1'b0, 0);
            drain();
        end

        // Fill the buffer until it stalls, then offer completions anyway
        req = "R7";
        repeat (6) tick(4'hF, 4'hF, 4'h0, 1'b0, 0);
        repeat (3) tick(4'hF, 4'hF, 4'hF, 1'b0, 0);
        drain();

        // Flush at a sweep of cut points over a mixed-age buffer
        req = "R9";
        for (int k = 0; k < 7; k++) begin
            tick(4'hF, 4'hF, 4'h0, 1'b0, 0);
            tick(4'hF, 4'hF, 4'b0010, 1'b0, 0);
            tick(4'hF, 4'hF, 4'h0, 1'b1, next_seq - 1 - k);
            drain();
        end

        // Random traffic with occasional flushes
        req = "R10";
        for (int c = 0; c < 1500; c++) begin
            logic [N-1:0] rv = 4'($urandom);
            logic [N-1:0] rn = 4'($urandom | $urandom);
            logic [N-1:0] rc = 4'($urandom & $urandom);
            bit           rf = ($urandom % 40) == 0;
            tick(rv, rn, rc, rf, next_seq - 1 - int'($urandom % 6));
        end
        drain();

        // Every owed tag must have been broadcast
        for (int t = 0; t < NTAGS; t++) chk(ledger[t] != 1, "R10", "needed tag never broadcast", t, -1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        done = 1'b1;
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R10 watchdog expired: actual 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule